// File: doc/BRIEF.md
# PWM Channel with Selectable Resolution

This block produces one pulse-width-modulated output from an 8-bit duty value. A power-of-two prescaler divides the system clock by 16, 32, 64 or 128. Each prescaler period advances a frame counter by one step. The output is high while the frame counter is below the duty value, so the duty value sets how many steps of each frame the pin stays high.

A single resolution bit chooses the frame length. In full resolution the frame is 256 steps long. In low resolution the frame is 32 steps long, and only the five low bits of the duty value count. The duty value and the resolution bit are captured into shadow registers only when a frame ends, so a change never cuts a frame short. A change of the prescaler select takes effect at once and restarts the prescaler from zero.

Top module: `pwm_res_channel`

## Requirements
- R1: The prescaler select picks the number of clocks per counter step: encoding 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128. The frame counter changes value only on a step.
- R2: With the resolution bit at 1, a frame lasts 32 steps (the counter runs 0..31). With the bit at 0, a frame lasts 256 steps (the counter runs 0..255).
- R3: In low resolution, bits 7..5 of the duty value have no effect: the duty values 0xE5 and 0x05 give the same output.
- R4: The output is high exactly while the frame counter is below the effective duty value. A duty of 0 keeps the output low, and a full-resolution duty of 255 keeps it high for 255 of 256 steps. Over any window of one frame, the number of high clocks equals the duty times the divide ratio.
- R5: The duty value and the resolution bit are sampled only on the step that ends a frame. A change made in mid-frame does not alter the current frame and applies from the next frame on.
- R6: When the prescaler select changes, the prescaler count restarts from zero on the next clock, so the next step comes one full new ratio after that restart.
- R7: While reset (active low) is asserted the output is low. Reset clears the frame counter and the prescaler, sets the shadow duty to 0 and the shadow resolution to full, so the output stays low for the whole first frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divSel | input | 2 | Prescaler select: divide by 16, 32, 64 or 128 |
| lowRes | input | 1 | 1 selects a 32-step frame, 0 selects a 256-step frame |
| dutyIn | input | 8 | Duty value, taken at frame end |
| pwmOut | output | 1 | PWM output pin |

## Verification
The duty is tested with 0, 64, 128 and 255 at full resolution, and with 0xE5, 0xFF, 10 and 3 at low resolution, under all four divide ratios. The high-clock count over a frame-long window separates the ratios and the frame lengths, and shows whether the high bits are masked. Two tests start at a frame boundary taken from the rising output. One changes the duty in mid-frame, which shows whether the shadow registers really wait for the frame end. The other changes the divide ratio, and the exact length of the first pulse shows whether the prescaler restarts. A behavioural model run beside the design compares the pin on every clock.

// File: rtl/pwm_res_pkg.sv
package pwm_res_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic step;   // advance the frame counter by one
    logic load;   // frame ends: wrap the counter and capture the shadows
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_res_ctrl.sv
module pwm_res_ctrl
  import pwm_res_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             atTop,
  output pwmStrobe_t       strobe
);

  localparam int NUM_DIV = 1 << SEL_W;
  localparam int PRESC_W = BASE_LOG2 + NUM_DIV - 1;

  logic [PRESC_W-1:0] termTbl [NUM_DIV];
  logic [PRESC_W-1:0] prescCnt;
  logic [SEL_W-1:0]   selQ;
  logic               selChanged;
  logic               prescDone;

  // Terminal count for each select value: 2^(BASE_LOG2+g) - 1
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
    assign termTbl[g] = {PRESC_W{1'b1}} >> (NUM_DIV - 1 - g);
  end

  assign selChanged = (divSel != selQ);
  assign prescDone  = !selChanged && (prescCnt == termTbl[divSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= '0;
      prescCnt <= '0;
    end else begin
      selQ <= divSel;
      if (selChanged || prescDone) prescCnt <= '0;
      else                         prescCnt <= prescCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.step = prescDone;
    strobe.load = prescDone && atTop;
  end

  // R1: with a steady select the count stays within that ratio
  p_presc_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == selQ) |-> (prescCnt <= termTbl[divSel]));

  // R1: the smallest ratio is 16, so two steps are never adjacent
  p_step_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> !strobe.step);

  // R6: a select change restarts the prescaler
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (divSel != $past(divSel)) |=> (prescCnt == '0));

  // R5: a frame can end only on a step
  p_load_on_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> strobe.step);

endmodule

// File: rtl/pwm_res_datapath.sv
module pwm_res_datapath
  import pwm_res_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOW_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [DATA_W-1:0] dutyIn,
  input  logic              lowRes,
  output logic              atTop,
  output logic              pwmOut
);

  localparam logic [DATA_W-1:0] FULL_MAX = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] LOW_MAX  = {{(DATA_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic [DATA_W-1:0] frameCnt;
  logic [DATA_W-1:0] dutyQ;
  logic              lowModeQ;
  logic [DATA_W-1:0] effDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      dutyQ    <= '0;
      lowModeQ <= 1'b0;
    end else if (strobe.load) begin
      frameCnt <= '0;
      dutyQ    <= dutyIn;
      lowModeQ <= lowRes;
    end else if (strobe.step) begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  assign effDuty = lowModeQ ? (dutyQ & LOW_MAX) : dutyQ;
  assign atTop   = (frameCnt == (lowModeQ ? LOW_MAX : FULL_MAX));
  assign pwmOut  = (frameCnt < effDuty);

  // R2: a low-resolution frame never passes 31
  p_low_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    lowModeQ |-> (frameCnt <= LOW_MAX));

  // R1: the counter holds between steps
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(frameCnt));

  // R5: the shadows change only when a frame ends
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(dutyQ) && $stable(lowModeQ)));

  // R4: a full-resolution duty of 255 is low only on the last step
  p_full_duty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!lowModeQ && dutyQ == FULL_MAX && frameCnt != FULL_MAX) |-> pwmOut);

  // R3: the high bits of the duty have no effect in low resolution
  p_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lowModeQ && dutyQ[LOW_W-1:0] == '0) |-> !pwmOut);

  // R7: the output is low during reset
  always @(posedge clk) begin
    if (!rstN) p_reset_low_r7: assert (!pwmOut);
  end

endmodule

// File: rtl/pwm_res_channel.sv
module pwm_res_channel
  import pwm_res_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOW_W     = 5,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  divSel,
  input  logic              lowRes,
  input  logic [DATA_W-1:0] dutyIn,
  output logic              pwmOut
);

  pwmStrobe_t strobe;
  logic       atTop;

  pwm_res_ctrl #(
    .SEL_W    (SEL_W),
    .BASE_LOG2(BASE_LOG2)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .divSel(divSel),
    .atTop (atTop),
    .strobe(strobe)
  );

  pwm_res_datapath #(
    .DATA_W(DATA_W),
    .LOW_W (LOW_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .dutyIn(dutyIn),
    .lowRes(lowRes),
    .atTop (atTop),
    .pwmOut(pwmOut)
  );

endmodule

// File: tb/sim_pwm_res_channel.sv
`timescale 1ns/1ps
module sim_pwm_res_channel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic       lowRes = 1'b0;
  logic [7:0] dutyIn = 8'd255;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int  mPresc = 0, mSelPrev = 0, mCnt = 0, mDuty = 0;
  bit  mLow = 0;
  bit  modelRun = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_res_channel u0 (
    .clk(clk), .rstN(rstN), .divSel(divSel), .lowRes(lowRes),
    .dutyIn(dutyIn), .pwmOut(pwmOut)
  );

  // Reference model: updated on every rising edge from the input values
  always @(posedge clk) begin
    bit tick;
    if (!rstN) begin
      mPresc = 0; mSelPrev = 0; mCnt = 0; mDuty = 0; mLow = 0;
    end else begin
      tick = 0;
      if (int'(divSel) != mSelPrev) begin
        mPresc = 0;
        mSelPrev = int'(divSel);
      end else if (mPresc == (16 << int'(divSel)) - 1) begin
        mPresc = 0;
        tick = 1;
      end else begin
        mPresc++;
      end
      if (tick) begin
        if (mCnt == (mLow ? 31 : 255)) begin
          mCnt = 0;
          mDuty = int'(dutyIn);
          mLow = lowRes;
        end else begin
          mCnt++;
        end
      end
    end
    modelRun = 1;
  end

  // Per-clock comparison (R4, R5, R6 and R1 through the model)
  always @(negedge clk) begin
    int effD;
    bit exp;
    if (modelRun && rstN && !finished) begin
      effD = mLow ? (mDuty % 32) : mDuty;
      exp = (mCnt < effD);
      checks++;
      if (pwmOut !== exp) begin
        errors++;
        $display("FAIL R4/R5 per-clock model at cycle %0d: actual %0b expected %0b",
                 cycles, pwmOut, exp);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected under 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measureHigh(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  // Returns at the negedge where the output has just gone high (frame start)
  task automatic waitRise();
    logic prevV;
    do begin
      prevV = pwmOut;
      @(negedge clk);
    end while (!(pwmOut && !prevV));
  endtask

  initial begin
    int hi;
    waitCycles(3);
    checkVal("R7 output low in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    // R7: shadow duty is 0 after reset, so the first frame stays low
    measureHigh(4000, hi);
    checkVal("R7 first frame after reset low", hi, 0);

    // R4 / R1: div16, full resolution
    dutyIn = 8'd64;
    waitCycles(8192);
    measureHigh(4096, hi);
    checkVal("R4 duty 64 div16 full", hi, 1024);

    dutyIn = 8'd0;
    waitCycles(8192);
    measureHigh(4096, hi);
    checkVal("R4 duty 0 always low", hi, 0);

    dutyIn = 8'd255;
    waitCycles(8192);
    measureHigh(4096, hi);
    checkVal("R4 duty 255 full", hi, 4080);

    // R2 / R3: low resolution, high bits masked
    lowRes = 1'b1;
    dutyIn = 8'hE5;
    waitCycles(8192);
    measureHigh(512, hi);
    checkVal("R3 duty 0xE5 low-res acts as 5", hi, 80);

    dutyIn = 8'hFF;
    waitCycles(1024);
    measureHigh(512, hi);
    checkVal("R2 duty 0xFF low-res 32-step frame", hi, 496);

    // R5: mid-frame duty change waits for the frame end
    dutyIn = 8'd5;
    waitCycles(1024);
    waitRise();
    hi = 1;
    for (int i = 1; i < 512; i++) begin
      if (i == 100) dutyIn = 8'd20;
      @(negedge clk);
      if (pwmOut) hi++;
    end
    checkVal("R5 mid-frame change ignored in current frame", hi, 80);
    measureHigh(512, hi);
    checkVal("R5 new duty applied next frame", hi, 320);

    // R1: div32
    divSel = 2'd1;
    dutyIn = 8'd10;
    waitCycles(2048);
    measureHigh(1024, hi);
    checkVal("R1 div32 low-res duty 10", hi, 320);

    // R6: switch to div16 exactly at frame start; first pulse is 161 clocks
    waitRise();
    divSel = 2'd0;
    hi = 1;
    forever begin
      @(negedge clk);
      if (pwmOut) hi++;
      else break;
    end
    checkVal("R6 prescaler restart on select change", hi, 161);

    // R1: div64
    divSel = 2'd2;
    dutyIn = 8'd3;
    waitCycles(4096);
    measureHigh(2048, hi);
    checkVal("R1 div64 low-res duty 3", hi, 192);

    // R1 / R2: div128, back to full resolution
    divSel = 2'd3;
    lowRes = 1'b0;
    dutyIn = 8'd128;
    waitCycles(37000);
    measureHigh(32768, hi);
    checkVal("R2 div128 full duty 128", hi, 16384);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule